// File: doc/BRIEF.md
# Coarse-Fine High-Resolution PWM Channel

This block produces one pulse-width-modulated output whose edges are placed with a resolution finer than the fabric clock. Each time value is split into two parts. A whole-cycle part is resolved by a free-running counter in the clock domain. A sub-cycle tap code is driven out to an external programmable delay line, which shifts the edge between two clock ticks. The delay line sits outside this block. With 32 taps per clock, the tap code covers exactly one clock period, so the coarse and fine parts never overlap. The channel is small, so many copies (up to 64) can sit side by side, each with its own registers and output.

Software writes a shadow register set over a plain write port: control, period and pulse width. The waveform always comes from a separate active set. A commit request copies shadow into active, and the copy happens only when the counter wraps back to zero, so the period in progress always finishes with the old settings. The commit request comes from one of two sources. A mode bit in the shadow control word selects either a write to the commit address or a rising edge on an external event pin. The event pin is resynchronised with two flops and then edge-detected.

The commit logic is a two-state machine. `CM_IDLE` waits for a request. `CM_PEND` holds a request that has not been applied yet. When a request arrives at a boundary, or the machine is pending when a boundary comes, the copy is made and the machine goes to `CM_IDLE`. When a request arrives away from a boundary, the machine goes from `CM_IDLE` to `CM_PEND`.

The wave generator is a five-state machine that is re-evaluated every cycle from the next counter value and the next active set:
- `WV_OFF`: the channel is disabled.
- `WV_ZERO`: the width is zero.
- `WV_FULL`: the width is at least the period.
- `WV_HIGH`: the counter is inside the pulse.
- `WV_LOW`: the counter is past the pulse.

Top module: `hrpwm_channel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pwm_gate` is 0 and both fine codes are 0. The active and shadow sets are cleared, so the channel starts disabled.
- R2: Writes go only to the shadow set. Addresses and fields:
  - Address 0 is control: bit 0 enable, bit 1 external-commit mode, bits 6:2 lead fine code.
  - Address 1 is the period in clock cycles, in bits COARSE_W-1:0. A value of 0 acts as 1.
  - Address 2 is the width: fine code in bits 4:0, coarse count in bits COARSE_W+4:5.
  - Without a commit, the output is unchanged by any shadow write.
- R3: While enabled with a period of P cycles, the counter runs 0..P-1 and wraps. `pwm_gate` is 1 while the count is below the width's coarse field C, and 0 from count C to P-1. Every period therefore starts with a rising edge at count 0.
- R4: During a normal pulse (0 < C < P), `fine_rise` presents the lead fine code and `fine_fall` presents the width's fine field for the whole period.
- R5: A width coarse field of 0 keeps `pwm_gate` at 0 for the whole period, with both fine codes 0.
- R6: A width coarse field equal to or greater than the period keeps `pwm_gate` at 1 with no falling edge, with both fine codes 0. This includes a period of 1.
- R7: In write-commit mode (shadow control bit 1 = 0), a write to address 3 copies the shadow set into the active set at the next wrap to count 0. The period in progress completes with the old settings.
- R8: In external-commit mode (shadow control bit 1 = 1), a rising edge on `ext_commit` requests the commit. The request becomes effective three clock edges after the pin is sampled high, and the copy is made at the next boundary. A write to address 3 is ignored in this mode. The external pin is ignored in write-commit mode.
- R9: While the active enable bit is 0, the counter is held at 0 and all outputs are 0. A commit made while disabled takes effect at the next clock edge.
- R10: A commit request stays pending until the next boundary. Several requests within one period cause a single copy, taken from the shadow contents at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 width, 3 commit) |
| wr_data | input | DATA_W | Register write data |
| ext_commit | input | 1 | Asynchronous external commit event |
| pwm_gate | output | 1 | Coarse PWM waveform to the delay line |
| fine_rise | output | FINE_W | Tap code for the rising edge |
| fine_fall | output | FINE_W | Tap code for the falling edge |

## Verification
The hardest situation to reach from the ports is a commit request that lands exactly on, or just before, a period wrap. In that case, the gap between the request and the copy depends on the synchroniser latency and on whether the machine is already pending.

The stimulus drives the event pin in several ways:
- pulses timed against short periods, so the synchronised edge falls on a wrap in some runs and mid-period in others;
- commit writes repeated within a single period, with shadow edits between them;
- commits made while the channel is disabled, where every cycle is a boundary.

A cycle-level reference model in the bench tracks the counter, the pending flag and both register sets, and it is compared with the outputs on every clock.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_WIDTH  = 2'd2,
        ADDR_COMMIT = 2'd3
    } hrpwm_addr_e;

    typedef enum logic {
        CM_IDLE = 1'b0,
        CM_PEND = 1'b1
    } commit_state_e;

    typedef enum logic [2:0] {
        WV_OFF  = 3'd0,
        WV_ZERO = 3'd1,
        WV_HIGH = 3'd2,
        WV_LOW  = 3'd3,
        WV_FULL = 3'd4
    } wave_state_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_EXT_BIT  = 1;
    localparam int CTRL_LEAD_LSB = 2;

endpackage

// File: rtl/hrpwm_evt_sync.sv
module hrpwm_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_rise
);
    // two synchroniser flops followed by one edge-history flop
    logic [2:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[1:0], evt_in};
        end
    end

    assign evt_rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/hrpwm_regfile.sv
module hrpwm_regfile
    import hrpwm_pkg::*;
#(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 5,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                evt_rise,
    input  logic                boundary,
    output logic                commit_now,
    output commit_state_e       cm_state,
    output logic                shd_en,
    output logic [FINE_W-1:0]   shd_lead,
    output logic [COARSE_W-1:0] shd_period,
    output logic [COARSE_W-1:0] shd_wc,
    output logic [FINE_W-1:0]   shd_wf,
    output logic                act_en,
    output logic [FINE_W-1:0]   act_lead,
    output logic [COARSE_W-1:0] act_period,
    output logic [COARSE_W-1:0] act_wc,
    output logic [FINE_W-1:0]   act_wf
);
    localparam int WIDTH_MSB = FINE_W + COARSE_W - 1;

    logic          shd_ext;
    logic          commit_req;
    commit_state_e cm_next;

    // shadow set: the only target of software writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_en     <= 1'b0;
            shd_ext    <= 1'b0;
            shd_lead   <= '0;
            shd_period <= '0;
            shd_wc     <= '0;
            shd_wf     <= '0;
        end else if (wr_en) begin
            unique case (hrpwm_addr_e'(wr_addr))
                ADDR_CTRL: begin
                    shd_en   <= wr_data[CTRL_EN_BIT];
                    shd_ext  <= wr_data[CTRL_EXT_BIT];
                    shd_lead <= wr_data[CTRL_LEAD_LSB +: FINE_W];
                end
                ADDR_PERIOD: shd_period <= wr_data[COARSE_W-1:0];
                ADDR_WIDTH: begin
                    shd_wf <= wr_data[FINE_W-1:0];
                    shd_wc <= wr_data[WIDTH_MSB:FINE_W];
                end
                ADDR_COMMIT: ;
                default: ;
            endcase
        end
    end

    // the request source is picked by the mode bit software is writing now
    assign commit_req = shd_ext ? evt_rise
                                : (wr_en && (hrpwm_addr_e'(wr_addr) == ADDR_COMMIT));

    // commit machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_state <= CM_IDLE;
        end else begin
            cm_state <= cm_next;
        end
    end

    // commit machine: transitions and outputs
    always_comb begin
        cm_next    = cm_state;
        commit_now = 1'b0;
        unique case (cm_state)
            CM_IDLE: begin
                if (commit_req && boundary) begin
                    commit_now = 1'b1;
                end else if (commit_req) begin
                    cm_next = CM_PEND;
                end
            end
            CM_PEND: begin
                if (boundary) begin
                    commit_now = 1'b1;
                    cm_next    = CM_IDLE;
                end
            end
            default: cm_next = CM_IDLE;
        endcase
    end

    // active set: copied from shadow only at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_en     <= 1'b0;
            act_lead   <= '0;
            act_period <= '0;
            act_wc     <= '0;
            act_wf     <= '0;
        end else if (commit_now) begin
            act_en     <= shd_en;
            act_lead   <= shd_lead;
            act_period <= shd_period;
            act_wc     <= shd_wc;
            act_wf     <= shd_wf;
        end
    end
endmodule

// File: rtl/hrpwm_wave.sv
module hrpwm_wave
    import hrpwm_pkg::*;
#(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act_en,
    input  logic [COARSE_W-1:0] act_period,
    input  logic                nxt_en,
    input  logic [FINE_W-1:0]   nxt_lead,
    input  logic [COARSE_W-1:0] nxt_period,
    input  logic [COARSE_W-1:0] nxt_wc,
    input  logic [FINE_W-1:0]   nxt_wf,
    output logic [COARSE_W-1:0] cnt_q,
    output logic [COARSE_W-1:0] last_c,
    output logic                boundary,
    output wave_state_e         wv_state,
    output logic                pwm_gate,
    output logic [FINE_W-1:0]   fine_rise,
    output logic [FINE_W-1:0]   fine_fall
);
    localparam logic [COARSE_W-1:0] ONE = COARSE_W'(1);

    logic [COARSE_W-1:0] act_len;
    logic [COARSE_W-1:0] nxt_len;
    logic [COARSE_W-1:0] cnt_nxt;
    wave_state_e         wv_next;
    logic                gate_nxt;
    logic [FINE_W-1:0]   rise_nxt;
    logic [FINE_W-1:0]   fall_nxt;

    // a period of zero behaves as a one-cycle period
    assign act_len  = (act_period == '0) ? ONE : act_period;
    assign nxt_len  = (nxt_period == '0) ? ONE : nxt_period;
    assign last_c   = act_len - ONE;
    assign boundary = !act_en || (cnt_q == last_c);
    assign cnt_nxt  = boundary ? '0 : (cnt_q + ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // wave machine: next state from next count and next active set
    always_comb begin
        if (!nxt_en) begin
            wv_next = WV_OFF;
        end else if (nxt_wc == '0) begin
            wv_next = WV_ZERO;
        end else if (nxt_wc >= nxt_len) begin
            wv_next = WV_FULL;
        end else if (cnt_nxt < nxt_wc) begin
            wv_next = WV_HIGH;
        end else begin
            wv_next = WV_LOW;
        end
    end

    // wave machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wv_state <= WV_OFF;
        end else begin
            wv_state <= wv_next;
        end
    end

    // wave machine: output decode, registered with the state
    always_comb begin
        gate_nxt = 1'b0;
        rise_nxt = '0;
        fall_nxt = '0;
        unique case (wv_next)
            WV_OFF:  ;
            WV_ZERO: ;
            WV_FULL: gate_nxt = 1'b1;
            WV_HIGH: begin
                gate_nxt = 1'b1;
                rise_nxt = nxt_lead;
                fall_nxt = nxt_wf;
            end
            WV_LOW: begin
                rise_nxt = nxt_lead;
                fall_nxt = nxt_wf;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_gate  <= 1'b0;
            fine_rise <= '0;
            fine_fall <= '0;
        end else begin
            pwm_gate  <= gate_nxt;
            fine_rise <= rise_nxt;
            fine_fall <= fall_nxt;
        end
    end
endmodule

// File: rtl/hrpwm_channel.sv
module hrpwm_channel
    import hrpwm_pkg::*;
#(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 5,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_commit,
    output logic              pwm_gate,
    output logic [FINE_W-1:0] fine_rise,
    output logic [FINE_W-1:0] fine_fall
);
    logic                evt_rise;
    logic                boundary;
    logic                commit_now;
    commit_state_e       cm_state;
    wave_state_e         wv_state;
    logic [COARSE_W-1:0] cnt_q;
    logic [COARSE_W-1:0] last_c;

    logic                shd_en,     act_en,     nxt_en;
    logic [FINE_W-1:0]   shd_lead,   act_lead,   nxt_lead;
    logic [COARSE_W-1:0] shd_period, act_period, nxt_period;
    logic [COARSE_W-1:0] shd_wc,     act_wc,     nxt_wc;
    logic [FINE_W-1:0]   shd_wf,     act_wf,     nxt_wf;

    hrpwm_evt_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (ext_commit),
        .evt_rise (evt_rise)
    );

    hrpwm_regfile #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .evt_rise   (evt_rise),
        .boundary   (boundary),
        .commit_now (commit_now),
        .cm_state   (cm_state),
        .shd_en     (shd_en),
        .shd_lead   (shd_lead),
        .shd_period (shd_period),
        .shd_wc     (shd_wc),
        .shd_wf     (shd_wf),
        .act_en     (act_en),
        .act_lead   (act_lead),
        .act_period (act_period),
        .act_wc     (act_wc),
        .act_wf     (act_wf)
    );

    // the set in force after this clock edge
    assign nxt_en     = commit_now ? shd_en     : act_en;
    assign nxt_lead   = commit_now ? shd_lead   : act_lead;
    assign nxt_period = commit_now ? shd_period : act_period;
    assign nxt_wc     = commit_now ? shd_wc     : act_wc;
    assign nxt_wf     = commit_now ? shd_wf     : act_wf;

    hrpwm_wave #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (act_en),
        .act_period (act_period),
        .nxt_en     (nxt_en),
        .nxt_lead   (nxt_lead),
        .nxt_period (nxt_period),
        .nxt_wc     (nxt_wc),
        .nxt_wf     (nxt_wf),
        .cnt_q      (cnt_q),
        .last_c     (last_c),
        .boundary   (boundary),
        .wv_state   (wv_state),
        .pwm_gate   (pwm_gate),
        .fine_rise  (fine_rise),
        .fine_fall  (fine_fall)
    );
endmodule

// File: rtl/hrpwm_channel_chk.sv
module hrpwm_channel_chk
    import hrpwm_pkg::*;
#(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [COARSE_W-1:0] cnt_q,
    input logic                boundary,
    input logic                commit_now,
    input commit_state_e       cm_state,
    input wave_state_e         wv_state,
    input logic                evt_rise,
    input logic                act_en,
    input logic [FINE_W-1:0]   act_lead,
    input logic [COARSE_W-1:0] act_period,
    input logic [COARSE_W-1:0] act_wc,
    input logic [FINE_W-1:0]   act_wf,
    input logic                pwm_gate,
    input logic [FINE_W-1:0]   fine_rise,
    input logic [FINE_W-1:0]   fine_fall
);
    logic [2*COARSE_W+2*FINE_W:0] act_bus;
    assign act_bus = {act_en, act_lead, act_period, act_wc, act_wf};

    // R1: outputs quiet during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!pwm_gate && fine_rise == '0 && fine_fall == '0)
                else $error("R1 outputs active in reset");
        end
    end

    // R9: disabled channel holds counter and output
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_en && !commit_now) |=> (cnt_q == '0 && !pwm_gate && fine_rise == '0 && fine_fall == '0));

    // R3: counter advances by one inside a period
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !boundary) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7: active set changes only across a boundary
    a_r7_active_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(act_bus));

    // R10: a pending request is released at the boundary
    a_r10_pend_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_state == CM_PEND && boundary) |=> (cm_state == CM_IDLE));

    // R5 / R6: fine codes only while a real pulse exists
    a_r6_fine_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_rise != '0 || fine_fall != '0) |-> (wv_state == WV_HIGH || wv_state == WV_LOW));

    // R8: a synchronised edge lasts a single cycle
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rise |=> !evt_rise);
endmodule

bind hrpwm_channel hrpwm_channel_chk #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_q      (cnt_q),
    .boundary   (boundary),
    .commit_now (commit_now),
    .cm_state   (cm_state),
    .wv_state   (wv_state),
    .evt_rise   (evt_rise),
    .act_en     (act_en),
    .act_lead   (act_lead),
    .act_period (act_period),
    .act_wc     (act_wc),
    .act_wf     (act_wf),
    .pwm_gate   (pwm_gate),
    .fine_rise  (fine_rise),
    .fine_fall  (fine_fall)
);

// File: tb/hrpwm_channel_tb_top.sv
module hrpwm_channel_tb_top;
    localparam int CW = 20;
    localparam int FW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          ext_commit = 1'b0;
    logic          pwm_gate;
    logic [FW-1:0] fine_rise;
    logic [FW-1:0] fine_fall;
    logic          dly_out;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #2 clk = ~clk;   // 250 MHz

    hrpwm_channel #(.COARSE_W(CW), .FINE_W(FW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_commit(ext_commit),
        .pwm_gate(pwm_gate), .fine_rise(fine_rise), .fine_fall(fine_fall)
    );

    // external delay line stands in as a pass-through
    assign dly_out = pwm_gate;

    // ---------------- reference model ----------------
    int m_cnt, m_pend;
    int a_en, a_lead, a_per, a_wc, a_wf;
    int s_en, s_ext, s_lead, s_per, s_wc, s_wf;
    bit ext_hist[$];
    int e_gate, e_rise, e_fall;

    task automatic model_reset();
        m_cnt = 0; m_pend = 0;
        a_en = 0; a_lead = 0; a_per = 0; a_wc = 0; a_wf = 0;
        s_en = 0; s_ext = 0; s_lead = 0; s_per = 0; s_wc = 0; s_wf = 0;
        ext_hist = '{0, 0, 0};
        e_gate = 0; e_rise = 0; e_fall = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int  len, len_new;
            bit  edge_seen, at_wrap, req, take;
            edge_seen = ext_hist[1] && !ext_hist[2];
            len = (a_per == 0) ? 1 : a_per;
            at_wrap = (a_en == 0) || (m_cnt == len - 1);
            if (s_ext) req = edge_seen;
            else       req = wr_en && (wr_addr == 2'd3);
            take = (m_pend || req) && at_wrap;
            m_pend = take ? 0 : (req ? 1 : m_pend);
            m_cnt = at_wrap ? 0 : m_cnt + 1;
            if (take) begin
                a_en = s_en; a_lead = s_lead; a_per = s_per; a_wc = s_wc; a_wf = s_wf;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin s_en = wr_data[0]; s_ext = wr_data[1]; s_lead = int'(wr_data[6:2]); end
                    2'd1: s_per = int'(wr_data[CW-1:0]);
                    2'd2: begin s_wf = int'(wr_data[4:0]); s_wc = int'(wr_data[CW+4:5]); end
                    default: ;
                endcase
            end
            void'(ext_hist.pop_back());
            ext_hist.push_front(ext_commit);
            len_new = (a_per == 0) ? 1 : a_per;
            e_gate = 0; e_rise = 0; e_fall = 0;
            if (a_en != 0 && a_wc != 0) begin
                if (a_wc >= len_new) e_gate = 1;
                else begin
                    e_gate = (m_cnt < a_wc) ? 1 : 0;
                    e_rise = a_lead;
                    e_fall = a_wf;
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("pwm_gate", int'(dly_out), e_gate);
            check("fine_rise", int'(fine_rise), e_rise);
            check("fine_fall", int'(fine_fall), e_fall);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulse(input int hi);
        @(negedge clk);
        ext_commit = 1'b1;
        repeat (hi) @(negedge clk);
        ext_commit = 1'b0;
    endtask

    function automatic int wword(input int c, input int f);
        return (c << 5) | f;
    endfunction

    function automatic int cword(input int en, input int ext, input int lead);
        return en | (ext << 1) | (lead << 2);
    endfunction

    initial begin
        #1 rst_n = 1'b0;
        cur_req = "R1";
        idle(3);
        check("R1 gate in reset", int'(pwm_gate), 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";                      // shadow only, no commit
        wr(0, cword(1, 0, 7));
        wr(1, 10);
        wr(2, wword(3, 9));
        idle(25);

        cur_req = "R9";                      // commit while disabled: next edge
        wr(3, 0);
        cur_req = "R3";
        idle(30);

        cur_req = "R4";                      // fine codes on a normal pulse
        wr(0, cword(1, 0, 21));
        wr(2, wword(5, 30));
        wr(3, 0);
        idle(25);

        cur_req = "R7";                      // mid-period commit waits for wrap
        idle(4);
        wr(2, wword(6, 2));
        wr(3, 0);
        idle(22);

        cur_req = "R10";                     // several requests, one copy
        wr(1, 7);
        wr(3, 0);
        wr(2, wword(2, 4));
        wr(3, 0);
        idle(20);

        cur_req = "R5";
        wr(2, wword(0, 17));
        wr(3, 0);
        idle(20);

        cur_req = "R6";
        wr(2, wword(7, 11));                 // equal to period
        wr(3, 0);
        idle(18);
        wr(2, wword(12, 3));                 // beyond period
        wr(3, 0);
        idle(18);
        wr(1, 1);                            // one-cycle period
        wr(2, wword(1, 5));
        wr(3, 0);
        idle(10);
        wr(1, 0);                            // period 0 acts as 1
        wr(3, 0);
        idle(6);

        cur_req = "R8";                      // external commit mode
        wr(1, 6);
        wr(2, wword(4, 1));
        wr(0, cword(1, 1, 3));
        wr(3, 0);                            // ignored in this mode
        idle(16);
        ext_pulse(2);
        idle(16);
        wr(2, wword(2, 8));
        for (int k = 0; k < 6; k++) begin    // sweep event phase against wrap
            idle(k);
            ext_pulse(1 + (k % 3));
            idle(9);
            wr(2, wword(1 + k % 5, k));
        end
        idle(10);
        wr(0, cword(1, 0, 3));               // back to write mode: pin ignored
        ext_pulse(2);
        idle(14);

        cur_req = "R9";                      // disable, then re-enable
        wr(0, cword(0, 0, 3));
        wr(3, 0);
        idle(15);
        wr(0, cword(1, 0, 9));
        wr(1, 5);
        wr(2, wword(2, 6));
        wr(3, 0);
        idle(15);

        cur_req = "R1";                      // reset mid-run
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(4);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule